// File: doc/BRIEF.md
# Serial Attenuator Programming Master

This block sits on the host side of a three-wire serial attenuator link. It takes a 5-bit attenuation code and produces the data, serial clock and latch-enable waveforms that load the code into a remote step attenuator. It builds a six-bit word whose first bit is always zero, followed by the code from its heaviest step (8 dB) down to its lightest (0.5 dB). It shifts that word out most significant bit first. It then raises latch enable once so the new setting takes effect.

Every timing limit is a parameter in nanoseconds. Each one is turned into a count of system clock cycles, rounded up so that no minimum is broken. The limits are the clock high time, the clock low time and the overall clock period, data setup before a rising edge, data hold after a falling edge, latch-enable setup after the last falling edge, and latch-enable pulse width. A separate hold-off limit sets the shortest spacing between two update starts.

Codes enter through a valid/ready handshake. A code is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the block is idle and the hold-off interval has run out. The block keeps no record of a valid presented while ready is low. A source that must deliver a code holds valid until it sees ready.

Top module: `atten_ser_master`

## Requirements
- R1: After reset `cmd_ready` is 1, `busy` and `done` are 0, and `ser_data`, `ser_clk` and `ser_le` are all 0.
- R2: Each update puts exactly six bits on `ser_data`, sampled at the rising edges of `ser_clk`. The first bit is 0, then `cmd_code[4]` down to `cmd_code[0]` (8, 4, 2, 1 and 0.5 dB weights).
- R3: With default parameters (10 ns system clock), every `ser_clk` high run lasts at least 5 cycles. Every low run between two rising edges lasts at least 5 cycles. This keeps the serial clock at or below 10 MHz and each half at or above 30 ns.
- R4: `ser_data` does not change while `ser_clk` is high. It does not change in the cycle `ser_clk` falls or in the cycle it rises, so it has at least one cycle (10 ns) of setup and of hold.
- R5: `ser_le` is 0 while `ser_clk` toggles. It rises at least one cycle after the last falling edge of `ser_clk`. It stays high for at least 3 cycles (30 ns) and pulses exactly once per update.
- R6: `done` is a one-cycle pulse in the first cycle that `ser_le` is low again. `busy` is 1 from the cycle after a code is taken until `ser_le` falls.
- R7: A `cmd_valid` presented while `cmd_ready` is 0 is ignored. It starts no update and does not change the word sent by the update in progress.
- R8: Two accepted codes are at least 4000 cycles apart (40 us, a 25 kHz update rate). `cmd_ready` stays 0 until then.
- R9: Between updates `ser_data`, `ser_clk` and `ser_le` rest at 0.
- R10: `cmd_ready` is never 1 while `busy` is 1. The first bit on `ser_data` is already 0 in the first busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Code offered on `cmd_code` |
| cmd_ready | output | 1 | Block can take a code this cycle |
| cmd_code | input | 5 | Attenuation code, bit 4 = 8 dB down to bit 0 = 0.5 dB |
| busy | output | 1 | An update is being shifted or latched |
| done | output | 1 | One-cycle pulse when an update has been latched |
| ser_data | output | 1 | Serial data to the attenuator |
| ser_clk | output | 1 | Serial clock to the attenuator |
| ser_le | output | 1 | Latch enable to the attenuator |

## Verification
The hardest case to reach from the ports is a valid offered while ready is low, both during shifting and during the idle hold-off after `done`. A handshake-respecting source never offers one. The directed tests pulse `cmd_valid` with a different code in the middle of a transfer and again just after `done`. They then check that the word captured from the wires is unchanged, that no extra latch pulse appears and that `busy` stays low. A monitor clocked on the falling system edge rebuilds every word from the rising edges of `ser_clk` and measures each high run, low run and data change against its edges.

// File: rtl/atten_ser_pkg.sv
package atten_ser_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_LOW     = 3'd1,
    ST_HIGH    = 3'd2,
    ST_LE_WAIT = 3'd3,
    ST_LE_HIGH = 3'd4
  } xfer_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Round a nanosecond limit up to whole clock cycles, never below one.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    return max2((ns + per - 1) / per, 1);
  endfunction

endpackage

// File: rtl/atten_phase_timer.sv
module atten_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               count <= '0;
    else if (restart)         count <= '0;
    else if (count != '1)     count <= count + 1'b1;
  end
endmodule

// File: rtl/atten_rate_gate.sv
module atten_rate_gate #(
  parameter int GAP_CYC = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic open_o
);
  localparam int GW = $clog2(GAP_CYC + 1);
  localparam logic [GW-1:0] RELOAD = GW'(GAP_CYC - 1);

  logic [GW-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain_q <= '0;
    else if (arm)            remain_q <= RELOAD;
    else if (remain_q != '0) remain_q <= remain_q - 1'b1;
  end

  assign open_o = (remain_q == '0);
endmodule

// File: rtl/atten_word_shifter.sv
module atten_word_shifter #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] word,
  input  logic         shift,
  input  logic         clear,
  output logic         msb
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sr_q <= '0;
    else if (clear)  sr_q <= '0;
    else if (load)   sr_q <= word;
    else if (shift)  sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign msb = sr_q[W-1];
endmodule

// File: rtl/atten_ser_master.sv
module atten_ser_master
  import atten_ser_pkg::*;
#(
  parameter int CODE_W             = 5,
  parameter int CLK_PERIOD_NS      = 10,
  parameter int SCLK_MIN_PERIOD_NS = 100,
  parameter int SCLK_HIGH_NS       = 30,
  parameter int SCLK_LOW_NS        = 30,
  parameter int DATA_SETUP_NS      = 10,
  parameter int DATA_HOLD_NS       = 10,
  parameter int LE_SETUP_NS        = 10,
  parameter int LE_WIDTH_NS        = 30,
  parameter int UPDATE_PERIOD_NS   = 40000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CODE_W-1:0] cmd_code,
  output logic              busy,
  output logic              done,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              ser_le
);
  localparam int WORD_W  = CODE_W + 1;
  localparam int HI_C    = ns_to_cyc(SCLK_HIGH_NS, CLK_PERIOD_NS);
  localparam int LO_C    = ns_to_cyc(SCLK_LOW_NS, CLK_PERIOD_NS);
  localparam int PER_C   = ns_to_cyc(SCLK_MIN_PERIOD_NS, CLK_PERIOD_NS);
  localparam int SETUP_C = ns_to_cyc(DATA_SETUP_NS, CLK_PERIOD_NS);
  localparam int HOLD_C  = ns_to_cyc(DATA_HOLD_NS, CLK_PERIOD_NS);
  localparam int LESU_C  = ns_to_cyc(LE_SETUP_NS, CLK_PERIOD_NS);
  localparam int LEW_C   = ns_to_cyc(LE_WIDTH_NS, CLK_PERIOD_NS);
  localparam int UPD_C   = ns_to_cyc(UPDATE_PERIOD_NS, CLK_PERIOD_NS);

  // Phase lengths in cycles, each the largest of the limits that bound it.
  localparam int HIGH_PH    = max2(HI_C, (PER_C + 1) / 2);
  localparam int LOW_PH     = max2(max2(LO_C, HOLD_C + SETUP_C), max2(PER_C, HIGH_PH) - HIGH_PH);
  localparam int LEWAIT_PH  = max2(LESU_C, HOLD_C);
  localparam int LEHIGH_PH  = LEW_C;
  localparam int MAX_PH     = max2(max2(HIGH_PH, LOW_PH), max2(LEWAIT_PH, LEHIGH_PH));
  localparam int CNT_W      = $clog2(MAX_PH + 1);
  localparam int IDX_W      = $clog2(WORD_W);

  localparam logic [CNT_W-1:0] HIGH_END   = CNT_W'(HIGH_PH - 1);
  localparam logic [CNT_W-1:0] LOW_END    = CNT_W'(LOW_PH - 1);
  localparam logic [CNT_W-1:0] LEWAIT_END = CNT_W'(LEWAIT_PH - 1);
  localparam logic [CNT_W-1:0] LEHIGH_END = CNT_W'(LEHIGH_PH - 1);
  localparam logic [CNT_W-1:0] SHIFT_AT   = CNT_W'(HOLD_C - 1);
  localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(WORD_W - 1);

  xfer_state_e       state_q, state_d;
  logic [CNT_W-1:0]  ph_cnt;
  logic [IDX_W-1:0]  idx_q;
  logic              accept, gate_open, shift_now, leave_latch, moving;
  logic              clk_q, le_q, done_q;
  logic [WORD_W-1:0] word;

  assign accept      = cmd_valid && cmd_ready;
  assign word        = {1'b0, cmd_code};
  assign moving      = (state_d != state_q);
  assign leave_latch = (state_q == ST_LE_HIGH) && (ph_cnt == LEHIGH_END);
  assign shift_now   = (state_q == ST_LOW) && (idx_q != '0) && (ph_cnt == SHIFT_AT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (accept) state_d = ST_LOW;
      ST_LOW:     if (ph_cnt == LOW_END) state_d = ST_HIGH;
      ST_HIGH:    if (ph_cnt == HIGH_END)
                    state_d = (idx_q == LAST_IDX) ? ST_LE_WAIT : ST_LOW;
      ST_LE_WAIT: if (ph_cnt == LEWAIT_END) state_d = ST_LE_HIGH;
      ST_LE_HIGH: if (ph_cnt == LEHIGH_END) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      clk_q   <= 1'b0;
      le_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      clk_q   <= (state_d == ST_HIGH);
      le_q    <= (state_d == ST_LE_HIGH);
      done_q  <= leave_latch;
      if (accept)
        idx_q <= '0;
      else if (state_q == ST_HIGH && state_d == ST_LOW)
        idx_q <= idx_q + 1'b1;
    end
  end

  atten_phase_timer #(.W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (moving),
    .count   (ph_cnt)
  );

  atten_rate_gate #(.GAP_CYC(UPD_C)) u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (accept),
    .open_o (gate_open)
  );

  atten_word_shifter #(.W(WORD_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .word  (word),
    .shift (shift_now),
    .clear (leave_latch),
    .msb   (ser_data)
  );

  assign cmd_ready = (state_q == ST_IDLE) && gate_open;
  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign ser_clk   = clk_q;
  assign ser_le    = le_q;

endmodule

// File: rtl/atten_ser_master_chk.sv
module atten_ser_master_chk #(
  parameter int HIGH_CYC = 5,
  parameter int LOW_CYC  = 5,
  parameter int LEW_CYC  = 3,
  parameter int GAP_CYC  = 4000
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic busy,
  input logic done,
  input logic ser_data,
  input logic ser_clk,
  input logic ser_le
);
  int unsigned hi_run, lo_run, le_run, since_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run    <= 0;
      lo_run    <= LOW_CYC;
      le_run    <= 0;
      since_acc <= GAP_CYC;
    end else begin
      hi_run <= ser_clk ? hi_run + 1 : 0;
      lo_run <= ser_clk ? 0 : ((lo_run < LOW_CYC) ? lo_run + 1 : lo_run);
      le_run <= ser_le ? le_run + 1 : 0;
      if (cmd_valid && cmd_ready) since_acc <= 1;
      else if (since_acc < GAP_CYC) since_acc <= since_acc + 1;
    end
  end

  p_start_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !ser_data);
  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !busy);
  p_high_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_clk) |-> hi_run >= HIGH_CYC);
  p_low_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk) |-> lo_run >= LOW_CYC);
  p_data_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_data));
  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_clk) |-> $stable(ser_data));
  p_data_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk) |-> $stable(ser_data));
  p_le_apart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ser_le |-> !ser_clk);
  p_le_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_le) |-> !$past(ser_clk));
  p_le_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_le) |-> le_run >= LEW_CYC);
  p_done_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ser_le && $past(ser_le)));
  p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |-> since_acc >= GAP_CYC);
  p_rest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_clk && !ser_le && !ser_data));
endmodule

bind atten_ser_master atten_ser_master_chk #(
  .HIGH_CYC (HIGH_PH),
  .LOW_CYC  (LOW_PH),
  .LEW_CYC  (LEHIGH_PH),
  .GAP_CYC  (UPD_C)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .busy      (busy),
  .done      (done),
  .ser_data  (ser_data),
  .ser_clk   (ser_clk),
  .ser_le    (ser_le)
);

// File: tb/atten_ser_master_tb.sv
`timescale 1ns/1ps
module atten_ser_master_tb_top;
  localparam int EXP_HIGH = 5;
  localparam int EXP_LOW  = 5;
  localparam int EXP_LEW  = 3;
  localparam int EXP_GAP  = 4000;
  localparam int NVEC     = 8;
  localparam logic [4:0] VEC [NVEC] = '{5'h00, 5'h1F, 5'h10, 5'h01, 5'h15, 5'h0A, 5'h08, 5'h13};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [4:0] cmd_code = '0;
  logic cmd_ready, busy, done, ser_data, ser_clk, ser_le;

  always #5 clk = ~clk;

  atten_ser_master dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .busy(busy), .done(done),
    .ser_data(ser_data), .ser_clk(ser_clk), .ser_le(ser_le)
  );

  int checks = 0;
  int errors = 0;

  // Waveform monitor, sampled on the falling system edge.
  int cyc = 0;
  logic p_clk = 0, p_le = 0, p_data = 0, p_busy = 0;
  logic [5:0] cap_word = '0;
  int cap_bits = 0, hi_run = 0, lo_run = 0, le_run = 0, le_pulses = 0;
  int bad_r3 = 0, bad_r4 = 0, bad_r5 = 0, bad_r6 = 0, bad_r9 = 0;
  int acc_cnt = 0, last_acc = -100000, bad_r8 = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc <= cyc + 1;
      if (busy && !p_busy) cap_bits <= 0;
      if (ser_clk && !p_clk) begin
        cap_word <= {cap_word[4:0], ser_data};
        if (!(busy && !p_busy)) cap_bits <= cap_bits + 1;
        if (lo_run < EXP_LOW && cap_bits > 0) bad_r3 <= bad_r3 + 1;
        if (ser_data != p_data) bad_r4 <= bad_r4 + 1;
        if (ser_le) bad_r5 <= bad_r5 + 1;
      end
      if (!ser_clk && p_clk) begin
        if (hi_run < EXP_HIGH) bad_r3 <= bad_r3 + 1;
        if (ser_data != p_data) bad_r4 <= bad_r4 + 1;
      end
      if (ser_clk && p_clk && ser_data != p_data) bad_r4 <= bad_r4 + 1;
      hi_run <= ser_clk ? hi_run + 1 : 0;
      lo_run <= ser_clk ? 0 : lo_run + 1;
      if (ser_le && !p_le) begin
        le_pulses <= le_pulses + 1;
        if (p_clk) bad_r5 <= bad_r5 + 1;
      end
      if (!ser_le && p_le) begin
        if (le_run < EXP_LEW) bad_r5 <= bad_r5 + 1;
        if (!done) bad_r6 <= bad_r6 + 1;
      end
      if (done && !(!ser_le && p_le)) bad_r6 <= bad_r6 + 1;
      le_run <= ser_le ? le_run + 1 : 0;
      if (!busy && !done && (ser_clk || ser_le || ser_data)) bad_r9 <= bad_r9 + 1;
      if (cmd_valid && cmd_ready) begin
        acc_cnt <= acc_cnt + 1;
        if (acc_cnt > 0 && cyc - last_acc < EXP_GAP) bad_r8 <= bad_r8 + 1;
        last_acc <= cyc;
      end
      p_clk <= ser_clk; p_le <= ser_le; p_data <= ser_data; p_busy <= busy;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    while (!cmd_ready) @(negedge clk);
  endtask

  // Send one code; optionally pulse a stray valid while busy.
  task automatic send(input logic [4:0] code, input bit stray);
    int p0;
    wait_ready();
    p0 = le_pulses;
    cmd_valid = 1'b1; cmd_code = code;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = ~code;
    @(negedge clk);
    chk(busy && !cmd_ready, "R10", {30'd0, busy, cmd_ready}, 2);
    if (stray) begin
      repeat (20) @(negedge clk);
      cmd_valid = 1'b1; cmd_code = ~code;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(!busy && !ser_le, "R6", {30'd0, busy, ser_le}, 0);
    @(negedge clk);
    chk(!done, "R6", {31'd0, done}, 0);
    chk(cap_word == {1'b0, code}, stray ? "R7" : "R2", cap_word, {1'b0, code});
    chk(cap_bits == 6, "R2", cap_bits, 6);
    chk(le_pulses == p0 + 1, "R5", le_pulses - p0, 1);
  endtask

  initial begin
    int acc0, le0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !ser_clk && !ser_le && !ser_data, "R1",
        {27'd0, busy, done, ser_clk, ser_le, ser_data}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready, "R1", cmd_ready, 1);

    for (int i = 0; i < NVEC; i++) send(VEC[i], 1'b0);

    // R7: stray valid mid-transfer must not alter the word.
    send(5'h06, 1'b1);

    // R7/R8: stray valid during hold-off after done is dropped.
    acc0 = acc_cnt; le0 = le_pulses;
    chk(!cmd_ready, "R8", cmd_ready, 0);
    cmd_valid = 1'b1; cmd_code = 5'h1B;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (100) @(negedge clk);
    chk(!busy && acc_cnt == acc0 && le_pulses == le0, "R7", acc_cnt - acc0, 0);

    send(5'h19, 1'b0);

    chk(bad_r3 == 0, "R3", bad_r3, 0);
    chk(bad_r4 == 0, "R4", bad_r4, 0);
    chk(bad_r5 == 0, "R5", bad_r5, 0);
    chk(bad_r6 == 0, "R6", bad_r6, 0);
    chk(bad_r8 == 0, "R8", bad_r8, 0);
    chk(bad_r9 == 0, "R9", bad_r9, 0);
    chk(acc_cnt == NVEC + 2, "R8", acc_cnt, NVEC + 2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule